// File: doc/BRIEF.md
# Low-Power Escape Receiver

This block listens to the two single-ended low-power inputs of one serial lane and recognises when the transmitter moves the lane into escape mode. No clock lane is used for this. Once the lane is in escape mode, the block recovers slow serial data from the line pair itself. It turns the recovered bits into bytes and watches for the pattern that ends escape mode.

The two line inputs pass through a two-stage synchronizer. Only a change of the synchronized two-bit line state counts as an event, so line levels may be held for any number of system clocks.

The entry pattern is a strict five-step walk. During reception, a pulse on the positive line carries a one and a pulse on the negative line carries a zero. Both lines return low between bits. A bit is committed when the lines go back to the all-low state. Eight bits, least significant first, make one byte. Any illegal step raises a one-cycle error pulse and drops the lane back to its idle watch.

Top module: `lp_escape_rx`

## Requirements
- R1: While reset is asserted and directly after it, `esc_active_o`, `byte_valid_o` and `err_o` are 0 and `byte_o` is 0.
- R2: Escape mode is entered only after the synchronized line state (bit 1 = positive line, bit 0 = negative line) walks through 11, 10, 00, 01, 00. `esc_active_o` rises three clock edges after the final 00 is applied.
- R3: During the entry walk, any line change that is not the next expected step gives a one-cycle `err_o` pulse. The detector then returns to waiting for a fresh transition into 11, and a failing step that is itself 11 does not count as that fresh transition.
- R4: While waiting for 11, changes to any other line state are ignored and raise no error.
- R5: In escape mode, the line sequence 00→10→00 delivers a bit of value 1 and 00→01→00 delivers a bit of value 0. The bit is committed when the lines return to 00.
- R6: Every eighth committed bit updates `byte_o`, with the first received bit in bit 0 and the last in bit 7, and `byte_valid_o` is high for exactly one cycle.
- R7: In escape mode, 10 followed by 11 ends escape mode without an error and discards a partial byte. After this exit the lane already counts as being in 11, so the entry walk may continue at 10.
- R8: In escape mode, a change into 11 that does not come straight from 10, or a direct swap between 10 and 01, gives an `err_o` pulse and clears `esc_active_o`. It never delivers a data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 2 | Raw low-power line levels, bit 1 positive line, bit 0 negative line |
| esc_active_o | output | 1 | High while the lane is in escape mode |
| byte_o | output | 8 | Last assembled byte |
| byte_valid_o | output | 1 | One-cycle strobe marking a new `byte_o` |
| err_o | output | 1 | One-cycle pulse on an illegal line sequence |

## Verification
The hardest case to reach is the ambiguity that the state 10 creates in escape mode. The same state can be the first half of a one bit or the first half of the exit pattern, and the block only knows which once the next state arrives. The stimulus reaches this case by exiting in the middle of a byte right after a 10 pulse. It then re-enters and sends a full byte, whose value shows whether any stale bit survived. A second sequence jumps from 00 straight to 11 in escape mode, and a third swaps 01 to 10 directly, to confirm that neither is taken as data.

// File: rtl/lp_esc_pkg.sv
package lp_esc_pkg;

  localparam logic [1:0] LN_STOP  = 2'b11;
  localparam logic [1:0] LN_POS   = 2'b10;
  localparam logic [1:0] LN_NEG   = 2'b01;
  localparam logic [1:0] LN_LOW   = 2'b00;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for a transition into the stop state
    ST_STOP,   // lane at 11, entry walk may begin
    ST_REQ,    // saw 10
    ST_GAP,    // saw 00 after 10
    ST_ACK,    // saw 01
    ST_DATA,   // escape mode, lines low between bits
    ST_MARK,   // escape mode, positive pulse seen
    ST_SPACE   // escape mode, negative pulse seen
  } esc_st_e;

  function automatic logic st_is_escape(esc_st_e st);
    return (st == ST_DATA) || (st == ST_MARK) || (st == ST_SPACE);
  endfunction

  function automatic logic [7:0] shift_lsb_first(logic [7:0] acc, logic b);
    return {b, acc[7:1]};
  endfunction

endpackage

// File: rtl/lp_line_sync.sv
module lp_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= d_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/esc_seq_fsm.sv
module esc_seq_fsm
  import lp_esc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_s,
  output logic       active_o,
  output logic       err_o,
  output logic       bit_stb_o,
  output logic       bit_val_o,
  output logic       entry_done_o,
  output logic       exit_o
);
  esc_st_e    st_q, st_d;
  logic [1:0] prev_q;
  logic       err_q, err_d;
  logic       ev;

  assign ev = (line_s != prev_q);

  always_comb begin
    st_d         = st_q;
    err_d        = 1'b0;
    bit_stb_o    = 1'b0;
    bit_val_o    = 1'b0;
    entry_done_o = 1'b0;
    exit_o       = 1'b0;
    if (ev) begin
      unique case (st_q)
        ST_IDLE:  if (line_s == LN_STOP) st_d = ST_STOP;
        ST_STOP:  if (line_s == LN_POS) st_d = ST_REQ; else err_d = 1'b1;
        ST_REQ:   if (line_s == LN_LOW) st_d = ST_GAP; else err_d = 1'b1;
        ST_GAP:   if (line_s == LN_NEG) st_d = ST_ACK; else err_d = 1'b1;
        ST_ACK:   if (line_s == LN_LOW) begin
                    st_d = ST_DATA;
                    entry_done_o = 1'b1;
                  end else err_d = 1'b1;
        ST_DATA:  if (line_s == LN_POS) st_d = ST_MARK;
                  else if (line_s == LN_NEG) st_d = ST_SPACE;
                  else err_d = 1'b1;
        ST_MARK:  if (line_s == LN_LOW) begin
                    st_d = ST_DATA;
                    bit_stb_o = 1'b1;
                    bit_val_o = 1'b1;
                  end else if (line_s == LN_STOP) begin
                    st_d = ST_STOP;
                    exit_o = 1'b1;
                  end else err_d = 1'b1;
        ST_SPACE: if (line_s == LN_LOW) begin
                    st_d = ST_DATA;
                    bit_stb_o = 1'b1;
                  end else err_d = 1'b1;
        default:  err_d = 1'b1;
      endcase
      if (err_d) st_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      prev_q <= LN_LOW;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      prev_q <= line_s;
      err_q  <= err_d;
    end
  end

  assign active_o = st_is_escape(st_q);
  assign err_o    = err_q;
endmodule

// File: rtl/esc_byte_asm.sv
module esc_byte_asm
  import lp_esc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              bit_stb_i,
  input  logic              bit_val_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] acc_q, acc_n;
  logic [CNT_W-1:0]  cnt_q;

  if (BYTE_W == 8) begin : g_fn
    assign acc_n = shift_lsb_first(acc_q, bit_val_i);
  end else begin : g_gen
    assign acc_n = {bit_val_i, acc_q[BYTE_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clr_i) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else if (bit_stb_i) begin
        acc_q <= acc_n;
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          byte_o  <= acc_n;
          valid_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lp_escape_rx.sv
module lp_escape_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        line_i,
  output logic              esc_active_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              err_o
);
  logic [1:0] line_s;
  logic       bit_stb_w, bit_val_w, entry_done_w, exit_w;

  lp_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(line_i), .q_o(line_s)
  );

  esc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .line_s(line_s),
    .active_o(esc_active_o), .err_o(err_o),
    .bit_stb_o(bit_stb_w), .bit_val_o(bit_val_w),
    .entry_done_o(entry_done_w), .exit_o(exit_w)
  );

  esc_byte_asm #(.BYTE_W(BYTE_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .clr_i(!esc_active_o),
    .bit_stb_i(bit_stb_w), .bit_val_i(bit_val_w),
    .byte_o(byte_o), .valid_o(byte_valid_o)
  );
endmodule

// File: rtl/esc_rx_checker.sv
module esc_rx_checker (
  input logic clk,
  input logic rst_n,
  input logic esc_active,
  input logic byte_valid,
  input logic err,
  input logic entry_done,
  input logic exit_seen,
  input logic bit_stb
);
  assert_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(esc_active) |-> $past(entry_done));

  assert_err_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !esc_active);

  assert_valid_from_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(bit_stb));

  assert_valid_in_escape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> esc_active);

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  assert_exit_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exit_seen |=> (!esc_active && !err));

  assert_leave_reason_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(esc_active) |-> ($past(exit_seen) || err));
endmodule

bind lp_escape_rx esc_rx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .esc_active(esc_active_o),
  .byte_valid(byte_valid_o), .err(err_o), .entry_done(entry_done_w),
  .exit_seen(exit_w), .bit_stb(bit_stb_w)
);

// File: tb/test_lp_escape_rx.sv
module test_lp_escape_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] line_i = 2'b00;
  logic       esc_active_o, byte_valid_o, err_o;
  logic [7:0] byte_o;

  int n_chk = 0, n_bad = 0;
  int seen_err, seen_vld;
  logic [7:0] got_byte;

  always #5 clk = ~clk;

  lp_escape_rx i_lp_escape_rx (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .esc_active_o(esc_active_o),
    .byte_o(byte_o), .byte_valid_o(byte_valid_o), .err_o(err_o)
  );

  // vector: {line, err expected, valid expected, active after, byte}
  localparam int NV = 32;
  localparam logic [12:0] VEC [NV] = '{
    {2'b11,3'b000,8'h00}, {2'b10,3'b000,8'h00}, {2'b00,3'b000,8'h00},
    {2'b01,3'b000,8'h00}, {2'b00,3'b001,8'h00},
    {2'b10,3'b001,8'h00}, {2'b00,3'b001,8'h00}, {2'b01,3'b001,8'h00}, {2'b00,3'b001,8'h00},
    {2'b10,3'b001,8'h00}, {2'b00,3'b001,8'h00}, {2'b01,3'b001,8'h00}, {2'b00,3'b001,8'h00},
    {2'b01,3'b001,8'h00}, {2'b00,3'b001,8'h00}, {2'b10,3'b001,8'h00}, {2'b00,3'b001,8'h00},
    {2'b01,3'b001,8'h00}, {2'b00,3'b001,8'h00}, {2'b10,3'b001,8'h00}, {2'b00,3'b011,8'hA5},
    {2'b10,3'b001,8'h00}, {2'b11,3'b000,8'h00},
    {2'b01,3'b100,8'h00}, {2'b00,3'b000,8'h00}, {2'b11,3'b000,8'h00},
    {2'b10,3'b000,8'h00}, {2'b00,3'b000,8'h00}, {2'b01,3'b000,8'h00},
    {2'b11,3'b100,8'h00}, {2'b00,3'b000,8'h00}, {2'b11,3'b000,8'h00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] v);
    line_i = v;
    seen_err = 0;
    seen_vld = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (err_o) seen_err++;
      if (byte_valid_o) begin
        seen_vld++;
        got_byte = byte_o;
      end
    end
  endtask

  task automatic enter_from_stop();
    put(2'b10); put(2'b00); put(2'b01); put(2'b00);
  endtask

  task automatic send_byte(input logic [7:0] b, output int vld, output int errs);
    vld = 0; errs = 0;
    for (int i = 0; i < 8; i++) begin
      put(b[i] ? 2'b10 : 2'b01); vld += seen_vld; errs += seen_err;
      put(2'b00);                vld += seen_vld; errs += seen_err;
    end
  endtask

  initial begin
    int v, e;
    repeat (3) @(negedge clk);
    chk(!esc_active_o && !byte_valid_o && !err_o && byte_o == 8'h00, "R1 reset hold",
        {esc_active_o, byte_valid_o, err_o, byte_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!esc_active_o && !byte_valid_o && !err_o && byte_o == 8'h00, "R1 after reset",
        {esc_active_o, byte_valid_o, err_o, byte_o}, 0);

    // table: R2 entry, R5/R6 byte A5, R7 exit, R3/R4 entry errors
    for (int k = 0; k < NV; k++) begin
      put(VEC[k][12:11]);
      chk((seen_err != 0) == VEC[k][10], $sformatf("R3 err step %0d", k), seen_err, VEC[k][10]);
      chk((seen_vld != 0) == VEC[k][9], $sformatf("R6 valid step %0d", k), seen_vld, VEC[k][9]);
      if (VEC[k][9])
        chk(got_byte == VEC[k][7:0], $sformatf("R5 byte step %0d", k), got_byte, VEC[k][7:0]);
      chk(esc_active_o == VEC[k][8], $sformatf("R2 active step %0d", k), esc_active_o, VEC[k][8]);
    end

    // R8: 00 straight to 11 inside escape mode
    enter_from_stop();
    chk(esc_active_o, "R2 re-entry", esc_active_o, 1);
    put(2'b10); put(2'b00);
    put(2'b11);
    chk(seen_err == 1 && !esc_active_o && seen_vld == 0, "R8 both high",
        {seen_err, esc_active_o}, 2);

    // R7: exit mid-byte discards partial bits
    put(2'b00);
    chk(seen_err == 0, "R4 idle ignores 00", seen_err, 0);
    put(2'b11);
    enter_from_stop();
    put(2'b10); put(2'b00); put(2'b10); put(2'b00); put(2'b01); put(2'b00);
    put(2'b10);
    put(2'b11);
    chk(seen_err == 0 && !esc_active_o && seen_vld == 0, "R7 exit mid byte",
        {seen_err, esc_active_o, seen_vld}, 0);
    enter_from_stop();
    send_byte(8'h3C, v, e);
    chk(v == 1 && e == 0 && got_byte == 8'h3C, "R7 partial discarded", got_byte, 8'h3C);
    chk(esc_active_o, "R6 still active after byte", esc_active_o, 1);

    // R8: direct swap 01 -> 10
    put(2'b01);
    put(2'b10);
    chk(seen_err == 1 && !esc_active_o, "R8 swap", {seen_err, esc_active_o}, 2);

    // R1: reset while active
    put(2'b11);
    enter_from_stop();
    chk(esc_active_o, "R2 entry before reset", esc_active_o, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!esc_active_o && !err_o && !byte_valid_o && byte_o == 8'h00, "R1 reset mid escape",
        {esc_active_o, err_o, byte_valid_o, byte_o}, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule